// File: doc/BRIEF.md
# Half-Step Pixel Clock Divider

This block turns a fast display source clock into a pixel-rate timing reference. The division ratio comes from an 8-bit field that has one fractional bit and a built-in offset of two: a field value `F` divides by `(F + 2) / 2`. Every ratio from 1 up to 128.5 is therefore reachable in steps of one half. A half-integer ratio has no single period length. For those ratios the block alternates a short output period and a long output period, so that over two periods the average is exact.

The block has two outputs. The first is a divided clock with a duty cycle as close to even as the period allows. The second is a one-source-cycle strobe that marks the last cycle of every output period, for logic that stays in the source domain. A new field value is taken in only at the end of the current output period, so a change never cuts a period short.

A companion function in the package derives the field from the source frequency and the desired pixel frequency. For example, with a 600 MHz source and a 71 MHz target the field is 15, which gives 70.6 MHz.

Top module: `hsdiv_pixclk`

## Requirements
- R1: While `rst_n` is low, `pix_clk` and `pix_stb` are both 0.
- R2: For an even field value F that is held constant, every output period lasts exactly F/2 + 1 source cycles.
- R3: For an odd field value F that is held constant, output periods alternate between (F+1)/2 and (F+3)/2 source cycles. The short period comes first after the value is adopted.
- R4: With a field of 0, `pix_stb` is 1 on every cycle and `pix_clk` stays 1 (divide by one).
- R5: A change of `div_field` is adopted only at the end of the current output period. The period in progress completes at its old length, and the first period at the new value is the short one.
- R6: In an output period of L cycles, `pix_clk` is 1 for the first ceil(L/2) cycles and 0 for the rest. `pix_stb` is 1 only on the period's last cycle.
- R7: After reset is released, the first output period lasts one cycle. `div_field` is sampled at the end of it, so `pix_stb` is 1 in the first cycle after release.
- R8: The package function `field_from_rates` returns round(2 × source / pixel) − 2, with halves rounded up, clamped to the range 0 to 2^FIELD_W − 1.
- R9: At the largest field value (255), output periods alternate between 128 and 129 cycles, with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast display source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_field | input | FIELD_W | Divider field, one fractional bit, ratio = (value + 2) / 2 |
| pix_clk | output | 1 | Divided clock, registered |
| pix_stb | output | 1 | One-cycle strobe on the last cycle of each output period |

## Verification
The hardest situation to reach is a field change that lands in the middle of a long period while the alternating short/long phase is partway through. The stimulus moves between odd and even values while a long period is still running, so the period in progress must finish at its old length and the new value must start on its short period. A behavioural credit-accumulator model advances two half-cycles per source clock and restarts its credit on every adopted change. That model predicts the strobe on each clock. The duty cycle is checked separately at every strobe, by counting high cycles over the period just measured.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

  typedef enum logic { PH_SHORT = 1'b0, PH_LONG = 1'b1 } hsdiv_phase_e;

  // Source cycles in one output period for a field and phase.
  function automatic int period_cycles(int field, logic long_phase);
    int base;
    base = (field >> 1) + 1;
    if (((field & 1) != 0) && long_phase)
      base = base + 1;
    return base;
  endfunction

  // High cycles in a period of the given length (extra cycle goes high).
  function automatic int high_cycles(int len);
    return (len + 1) >> 1;
  endfunction

  // Divider field from the source and pixel rates, nearest, clamped.
  function automatic int field_from_rates(longint src_hz, longint pix_hz,
                                          int field_max);
    longint q;
    if (pix_hz <= 0)
      return field_max;
    q = (2 * src_hz + pix_hz / 2) / pix_hz - 2;
    if (q < 0)
      q = 0;
    if (q > longint'(field_max))
      q = longint'(field_max);
    return int'(q);
  endfunction

endpackage

// File: rtl/hsdiv_field_reg.sv
module hsdiv_field_reg #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic [FIELD_W-1:0] field_in,
  output logic [FIELD_W-1:0] field_q,
  output logic               long_phase
);
  import hsdiv_pkg::*;

  hsdiv_phase_e phase_q;
  logic         field_change;

  assign field_change = (field_in != field_q);
  assign long_phase   = (phase_q == PH_LONG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      phase_q <= PH_SHORT;
    end else if (boundary) begin
      if (field_change) begin
        field_q <= field_in;
        phase_q <= PH_SHORT;
      end else if (field_q[0] && (phase_q == PH_SHORT)) begin
        phase_q <= PH_LONG;
      end else begin
        phase_q <= PH_SHORT;
      end
    end
  end

  // R5
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(field_q));

  // R3
  long_only_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_phase |-> field_q[0]);

endmodule

// File: rtl/hsdiv_period_cnt.sv
module hsdiv_period_cnt #(
  parameter int FIELD_W = 8,
  localparam int LEN_W  = FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field_q,
  input  logic               long_phase,
  output logic               boundary,
  output logic               high
);
  import hsdiv_pkg::*;

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] hi_len;

  assign len      = LEN_W'(period_cycles(int'(field_q), long_phase));
  assign hi_len   = LEN_W'(high_cycles(int'(len)));
  assign boundary = (cnt == len - LEN_W'(1));
  assign high     = (cnt < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (boundary)
      cnt <= '0;
    else
      cnt <= cnt + LEN_W'(1);
  end

  // R9
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

  // R2
  restart_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0));

endmodule

// File: rtl/hsdiv_out_stage.sv
module hsdiv_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic high,
  output logic pix_clk,
  output logic pix_stb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_clk <= 1'b0;
      pix_stb <= 1'b0;
    end else begin
      pix_clk <= high;
      pix_stb <= boundary;
    end
  end

  // R6
  high_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |=> pix_clk);

endmodule

// File: rtl/hsdiv_pixclk.sv
module hsdiv_pixclk #(
  parameter int FIELD_W = 8
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] div_field,
  output logic               pix_clk,
  output logic               pix_stb
);

  logic [FIELD_W-1:0] field_q;
  logic               long_phase;
  logic               boundary;
  logic               high;

  hsdiv_field_reg #(.FIELD_W(FIELD_W)) u_field (
    .clk        (clk_src),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .field_in   (div_field),
    .field_q    (field_q),
    .long_phase (long_phase)
  );

  hsdiv_period_cnt #(.FIELD_W(FIELD_W)) u_cnt (
    .clk        (clk_src),
    .rst_n      (rst_n),
    .field_q    (field_q),
    .long_phase (long_phase),
    .boundary   (boundary),
    .high       (high)
  );

  hsdiv_out_stage u_out (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .boundary (boundary),
    .high     (high),
    .pix_clk  (pix_clk),
    .pix_stb  (pix_stb)
  );

  // R4
  div1_every_cycle_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (field_q == '0) |-> (boundary && high));

endmodule

// File: tb/tb_hsdiv_pixclk.sv
`timescale 1ns/1ps
module tb_hsdiv_pixclk;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] div_field = '0;
  logic          pix_clk;
  logic          pix_stb;

  always #2 clk = ~clk;

  hsdiv_pixclk #(.FIELD_W(FW)) dut (
    .clk_src   (clk),
    .rst_n     (rst_n),
    .div_field (div_field),
    .pix_clk   (pix_clk),
    .pix_stb   (pix_stb)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: credit accumulator in half-cycles (two per source cycle).
  int m_acc = 1;
  int m_f = 0;
  bit exp_stb = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 1; m_f = 0; exp_stb = 0;
    end else begin
      int tgt;
      tgt = m_f + 2;
      if (m_acc + 2 >= tgt) begin
        exp_stb = 1;
        if (int'(div_field) != m_f) begin
          m_f = int'(div_field); m_acc = 1;
        end else begin
          m_acc = m_acc + 2 - tgt;
        end
      end else begin
        exp_stb = 0;
        m_acc = m_acc + 2;
      end
    end
  end

  // Per-cycle comparison plus duty measurement at each strobe.
  int plen = 0;
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1 pix_clk", int'(pix_clk), 0);
        chk("R1 pix_stb", int'(pix_stb), 0);
        plen = 0; hi_cnt = 0;
      end else begin
        chk({cur_req, " strobe"}, int'(pix_stb), int'(exp_stb));
        plen++;
        if (pix_clk) hi_cnt++;
        if (pix_stb) begin
          chk("R6 high cycles", hi_cnt, (plen + 1) / 2);
          plen = 0; hi_cnt = 0;
        end
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    div_field = 8'd4;
    run(3);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk("R7 first strobe", int'(pix_stb), 1);
    cur_req = "R2"; run(40);
    div_field = 8'd9; cur_req = "R3"; run(60);
    div_field = 8'd0; cur_req = "R4"; run(25);
    chk("R4 clk high", int'(pix_clk), 1);
    chk("R4 strobe", int'(pix_stb), 1);
    div_field = 8'd1; cur_req = "R3"; run(20);
    div_field = 8'd40; cur_req = "R5"; run(30);
    div_field = 8'd6; run(40);
    div_field = 8'd13; run(17);
    div_field = 8'd2; run(30);
    div_field = 8'd255; cur_req = "R9"; run(700);
    div_field = 8'd254; cur_req = "R2"; run(300);
    rst_n = 1'b0; div_field = 8'd3; run(2);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk("R7 strobe after reset", int'(pix_stb), 1);
    cur_req = "R3"; run(30);
    // R8 helper function
    chk("R8 600/71", hsdiv_pkg::field_from_rates(600_000_000, 71_000_000, 255), 15);
    chk("R8 600/150", hsdiv_pkg::field_from_rates(600_000_000, 150_000_000, 255), 6);
    chk("R8 600/600", hsdiv_pkg::field_from_rates(600_000_000, 600_000_000, 255), 0);
    chk("R8 600/400", hsdiv_pkg::field_from_rates(600_000_000, 400_000_000, 255), 1);
    chk("R8 half up", hsdiv_pkg::field_from_rates(100, 80, 255), 1);
    chk("R8 clamp high", hsdiv_pkg::field_from_rates(600_000_000, 1_000_000, 255), 255);
    chk("R8 clamp low", hsdiv_pkg::field_from_rates(600_000_000, 2_000_000_000, 255), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule